// File: doc/BRIEF.md
# Run-level escape decoder

This block sits after an Exp-Golomb stage in a two-dimensional VLC residual decoder. It takes a stream of code numbers, one per accepted handshake, and turns them into (run, level) pairs. A code number below the escape threshold of 59 is an ordinary code. Combined with the current table number, it forms an index into an external run-level lookup, and the run and level that come back are registered and emitted.

A code number of 59 or more opens an escape. The run is worked out arithmetically as (code - 59) / 2, rounded down. That run and the table number index an external lookup of the reference absolute level. The block captures the returned reference level and the parity of the code, then waits for the next code number. That next code number is the level difference. The magnitude is the reference level plus the difference. It is negated when the opening code was odd.

Both lookups are combinational ports. The block drives an index and reads the answer in the same cycle.

Top module: `rl_escape_dec`

## Requirements
- R1: While `rst_n` is low, `out_valid_o` and `cn_ready_o` are both 0.
- R2: In a cycle where the block waits for a first code and `cn_value_i` < 59, `rl_idx_o` equals `{tbl_sel_i, cn_value_i[5:0]}`: the table number in the upper bits and the code in the low 6 bits.
- R3: A first code below 59 that is accepted on an edge gives `out_valid_o` = 1 for the following cycle. In that cycle `out_run_o` and `out_level_o` hold the lookup values present at the accept edge, and `out_esc_o` = 0.
- R4: For a first code of 59 or more, `ref_idx_o` equals `{tbl_sel_i, run}` in the accepting cycle, with run = (code - 59) / 2. No output pulse follows that accept.
- R5: After an escape opener, the next accepted code number is used as the level difference whatever its value. The cycle after it is accepted, `out_valid_o` = 1, `out_esc_o` = 1, and `out_run_o` is the run of the opener.
- R6: The escape level is -(ref + diff) when the opener was odd and +(ref + diff) when it was even.
- R7: The escape magnitude saturates at 2047, the largest positive value of the 12-bit signed level.
- R8: An escape run larger than 63 is clamped to 63, both on `ref_idx_o` and on `out_run_o`.
- R9: `out_valid_o` is high only in the cycle after an accept that completes a pair. Idle cycles between an escape opener and its difference keep the pending escape intact.
- R10: From the second cycle after reset release onward, `cn_ready_o` is 1 both while waiting for a first code and while waiting for a difference.
- R11: The reference level is captured in the cycle the opener is accepted. Later changes on `ref_abs_i` do not affect the escape level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cn_valid_i | input | 1 | Code number valid |
| cn_value_i | input | 12 | Code number |
| cn_ready_o | output | 1 | Code number accepted when high together with valid |
| tbl_sel_i | input | 5 | Current table number |
| rl_idx_o | output | 11 | Index to the run-level lookup |
| rl_run_i | input | 6 | Run returned by the run-level lookup |
| rl_level_i | input | 12 | Signed level returned by the run-level lookup |
| ref_idx_o | output | 11 | Index to the reference-level lookup |
| ref_abs_i | input | 11 | Reference absolute level returned by the lookup |
| out_valid_o | output | 1 | One-cycle pulse marking a decoded pair |
| out_run_o | output | 6 | Decoded run |
| out_level_o | output | 12 | Decoded signed level |
| out_esc_o | output | 1 | Pair came from an escape |

## Verification
Both lookup indices are combinational, so the bench checks them 1 ns after it drives a code, before the accepting edge. Each decoded pair sits behind exactly one register: the pair for an ordinary code, or for an escape difference, is checked at the falling edge that follows its accept edge. An escape opener must give no pulse at that same point. Idle cycles, including those inside a pending escape, are checked for a silent `out_valid_o` at every falling edge. The expected pair comes from the bench's own lookup functions and escape arithmetic.

// File: rtl/rlx_pkg.sv
package rlx_pkg;
    localparam int RLX_CN_W     = 12;
    localparam int RLX_TBL_W    = 5;
    localparam int RLX_RUN_W    = 6;
    localparam int RLX_LVL_W    = 12;
    localparam int RLX_ESC_BASE = 59;

    typedef enum logic [0:0] {
        RLX_IDLE      = 1'b0,
        RLX_WAIT_DIFF = 1'b1
    } rlx_state_e;
endpackage

// File: rtl/rlx_code_split.sv
// Classifies a code number and derives the clamped escape run.
module rlx_code_split #(
    parameter int CN_W     = 12,
    parameter int RUN_W    = 6,
    parameter int ESC_BASE = 59
) (
    input  logic [CN_W-1:0]  cn_i,
    output logic             is_esc_o,
    output logic             odd_o,
    output logic [RUN_W-1:0] run_o
);
    localparam int RUN_MAX = (1 << RUN_W) - 1;

    logic [CN_W-1:0] offs;
    logic [CN_W-1:0] half;

    always_comb begin
        is_esc_o = (cn_i >= CN_W'(ESC_BASE));
        odd_o    = cn_i[0];
        offs     = cn_i - CN_W'(ESC_BASE);
        half     = offs >> 1;
    end

    generate
        if (CN_W - 1 > RUN_W) begin : g_clamp
            always_comb begin
                if (!is_esc_o)
                    run_o = '0;
                else if (half > CN_W'(RUN_MAX))
                    run_o = RUN_W'(RUN_MAX);
                else
                    run_o = half[RUN_W-1:0];
            end
        end else begin : g_fit
            always_comb begin
                run_o = is_esc_o ? RUN_W'(half) : '0;
            end
        end
    endgenerate
endmodule

// File: rtl/rlx_level_join.sv
// Adds reference level and difference, saturates, applies sign.
module rlx_level_join #(
    parameter int CN_W  = 12,
    parameter int LVL_W = 12
) (
    input  logic [LVL_W-2:0]        ref_i,
    input  logic [CN_W-1:0]         diff_i,
    input  logic                    neg_i,
    output logic signed [LVL_W-1:0] level_o
);
    localparam int MAG_W   = LVL_W - 1;
    localparam int SUM_W   = ((MAG_W > CN_W) ? MAG_W : CN_W) + 1;
    localparam int MAG_MAX = (1 << MAG_W) - 1;

    logic [SUM_W-1:0] sum;
    logic [MAG_W-1:0] mag;
    logic signed [LVL_W-1:0] pos;

    always_comb begin
        sum = SUM_W'(ref_i) + SUM_W'(diff_i);
        if (sum > SUM_W'(MAG_MAX))
            mag = MAG_W'(MAG_MAX);
        else
            mag = sum[MAG_W-1:0];
        pos     = $signed({1'b0, mag});
        level_o = neg_i ? -pos : pos;
    end
endmodule

// File: rtl/rl_escape_dec.sv
module rl_escape_dec
    import rlx_pkg::*;
#(
    parameter int CN_W     = RLX_CN_W,
    parameter int TBL_W    = RLX_TBL_W,
    parameter int RUN_W    = RLX_RUN_W,
    parameter int LVL_W    = RLX_LVL_W,
    parameter int ESC_BASE = RLX_ESC_BASE
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cn_valid_i,
    input  logic [CN_W-1:0]         cn_value_i,
    output logic                    cn_ready_o,
    input  logic [TBL_W-1:0]        tbl_sel_i,
    output logic [TBL_W+$clog2(ESC_BASE)-1:0] rl_idx_o,
    input  logic [RUN_W-1:0]        rl_run_i,
    input  logic signed [LVL_W-1:0] rl_level_i,
    output logic [TBL_W+RUN_W-1:0]  ref_idx_o,
    input  logic [LVL_W-2:0]        ref_abs_i,
    output logic                    out_valid_o,
    output logic [RUN_W-1:0]        out_run_o,
    output logic signed [LVL_W-1:0] out_level_o,
    output logic                    out_esc_o
);
    localparam int NIDX_W = $clog2(ESC_BASE);
    localparam int MAG_W  = LVL_W - 1;

    typedef struct packed {
        rlx_state_e              st;
        logic                    rdy;
        logic                    ovld;
        logic [RUN_W-1:0]        orun;
        logic signed [LVL_W-1:0] olvl;
        logic                    oesc;
        logic [RUN_W-1:0]        erun;
        logic                    eneg;
        logic [MAG_W-1:0]        eref;
    } regs_t;

    regs_t r_d, r_q;

    logic                    is_esc;
    logic                    cn_odd;
    logic [RUN_W-1:0]        esc_run;
    logic signed [LVL_W-1:0] esc_level;
    logic                    accept;

    rlx_code_split #(
        .CN_W    (CN_W),
        .RUN_W   (RUN_W),
        .ESC_BASE(ESC_BASE)
    ) u_split (
        .cn_i    (cn_value_i),
        .is_esc_o(is_esc),
        .odd_o   (cn_odd),
        .run_o   (esc_run)
    );

    rlx_level_join #(
        .CN_W (CN_W),
        .LVL_W(LVL_W)
    ) u_join (
        .ref_i  (r_q.eref),
        .diff_i (cn_value_i),
        .neg_i  (r_q.eneg),
        .level_o(esc_level)
    );

    always_comb begin
        r_d      = r_q;
        r_d.rdy  = 1'b1;
        r_d.ovld = 1'b0;
        accept   = cn_valid_i && r_q.rdy;
        unique case (r_q.st)
            RLX_IDLE: begin
                if (accept) begin
                    if (is_esc) begin
                        r_d.st   = RLX_WAIT_DIFF;
                        r_d.erun = esc_run;
                        r_d.eneg = cn_odd;
                        r_d.eref = ref_abs_i;
                    end else begin
                        r_d.ovld = 1'b1;
                        r_d.orun = rl_run_i;
                        r_d.olvl = rl_level_i;
                        r_d.oesc = 1'b0;
                    end
                end
            end
            RLX_WAIT_DIFF: begin
                if (accept) begin
                    r_d.st   = RLX_IDLE;
                    r_d.ovld = 1'b1;
                    r_d.orun = r_q.erun;
                    r_d.olvl = esc_level;
                    r_d.oesc = 1'b1;
                end
            end
            default: r_d.st = RLX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rl_idx_o    = {tbl_sel_i, cn_value_i[NIDX_W-1:0]};
    assign ref_idx_o   = {tbl_sel_i, esc_run};
    assign cn_ready_o  = r_q.rdy;
    assign out_valid_o = r_q.ovld;
    assign out_run_o   = r_q.orun;
    assign out_level_o = r_q.olvl;
    assign out_esc_o   = r_q.oesc;
endmodule

// File: rtl/rlx_chk.sv
module rlx_chk #(
    parameter int CN_W     = 12,
    parameter int RUN_W    = 6,
    parameter int LVL_W    = 12,
    parameter int ESC_BASE = 59
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cn_valid_i,
    input logic [CN_W-1:0]         cn_value_i,
    input logic                    cn_ready_o,
    input logic [RUN_W-1:0]        rl_run_i,
    input logic signed [LVL_W-1:0] rl_level_i,
    input logic                    out_valid_o,
    input logic [RUN_W-1:0]        out_run_o,
    input logic signed [LVL_W-1:0] out_level_o,
    input logic                    out_esc_o
);
    localparam int LMAX = (1 << (LVL_W - 1)) - 1;

    logic acc;
    logic pend_q;
    logic odd_q;

    assign acc = cn_valid_i && cn_ready_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            odd_q  <= 1'b0;
        end else if (acc) begin
            if (!pend_q && cn_value_i >= CN_W'(ESC_BASE)) begin
                pend_q <= 1'b1;
                odd_q  <= cn_value_i[0];
            end else begin
                pend_q <= 1'b0;
            end
        end
    end

    AST_NORMAL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !pend_q && cn_value_i < CN_W'(ESC_BASE) |=> out_valid_o && !out_esc_o
            && out_run_o == $past(rl_run_i) && out_level_o == $past(rl_level_i)); // R3
    AST_OPENER_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !pend_q && cn_value_i >= CN_W'(ESC_BASE) |=> !out_valid_o); // R4
    AST_DIFF_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
        acc && pend_q |=> out_valid_o && out_esc_o); // R5
    AST_SIGN_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && out_esc_o && odd_q |-> out_level_o <= 0); // R6
    AST_SIGN_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && out_esc_o && !odd_q |-> out_level_o >= 0); // R6
    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && out_esc_o |-> out_level_o <= LMAX && out_level_o >= -LMAX); // R7
    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> $past(acc)); // R9
    AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cn_ready_o); // R10
endmodule

bind rl_escape_dec rlx_chk #(
    .CN_W    (CN_W),
    .RUN_W   (RUN_W),
    .LVL_W   (LVL_W),
    .ESC_BASE(ESC_BASE)
) u_rlx_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cn_valid_i (cn_valid_i),
    .cn_value_i (cn_value_i),
    .cn_ready_o (cn_ready_o),
    .rl_run_i   (rl_run_i),
    .rl_level_i (rl_level_i),
    .out_valid_o(out_valid_o),
    .out_run_o  (out_run_o),
    .out_level_o(out_level_o),
    .out_esc_o  (out_esc_o)
);

// File: tb/tb_rl_escape_dec.sv
`timescale 1ns/1ps
module tb_rl_escape_dec;
    logic               clk = 1'b0;
    logic               rst_n;
    logic               cn_valid_i;
    logic [11:0]        cn_value_i;
    logic               cn_ready_o;
    logic [4:0]         tbl_sel_i;
    logic [10:0]        rl_idx_o;
    logic [5:0]         rl_run_i;
    logic signed [11:0] rl_level_i;
    logic [10:0]        ref_idx_o;
    logic [10:0]        ref_abs_i;
    logic               out_valid_o;
    logic [5:0]         out_run_o;
    logic signed [11:0] out_level_o;
    logic               out_esc_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    bit ref_force = 0;
    int ref_alt = 0;
    string lvl_tag = "";

    bit m_pend = 0;
    int m_run, m_neg, m_ref;

    always #10 clk = ~clk;

    rl_escape_dec dut (.*);

    function automatic int f_run(int idx);  return (idx * 7 + 3) % 64; endfunction
    function automatic int f_lvl(int idx);  return ((idx * 37) % 4095) - 2047; endfunction
    function automatic int f_ref(int idx);  return (idx * 13 + 5) % 2048; endfunction

    always_comb begin
        rl_run_i   = 6'(f_run(int'(rl_idx_o)));
        rl_level_i = 12'(f_lvl(int'(rl_idx_o)));
        ref_abs_i  = ref_force ? 11'(ref_alt) : 11'(f_ref(int'(ref_idx_o)));
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(out_valid_o == 1'b0, "R9", out_valid_o, 0);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic push(int cn, int tbl);
        int idx, r, mag, er, el;
        bit ev, ee;
        string tg;
        cn_valid_i = 1'b1;
        cn_value_i = 12'(cn);
        tbl_sel_i  = 5'(tbl);
        #1;
        chk(cn_ready_o == 1'b1, "R10", cn_ready_o, 1);
        ev = 0; ee = 0; er = 0; el = 0; tg = "R3";
        if (!m_pend) begin
            if (cn < 59) begin
                idx = tbl * 64 + cn;
                chk(int'(rl_idx_o) == idx, "R2", rl_idx_o, idx);
                ev = 1; er = f_run(idx); el = f_lvl(idx);
            end else begin
                r = (cn - 59) / 2;
                if (r > 63) r = 63;
                idx = tbl * 64 + r;
                chk(int'(ref_idx_o) == idx, ((cn - 59) / 2 > 63) ? "R8" : "R4",
                    ref_idx_o, idx);
                m_pend = 1; m_run = r; m_neg = cn % 2;
                m_ref = ref_force ? ref_alt : f_ref(idx);
            end
        end else begin
            mag = m_ref + cn;
            tg = "R6";
            if (mag > 2047) begin mag = 2047; tg = "R7"; end
            el = m_neg ? -mag : mag;
            er = m_run; ee = 1; ev = 1; m_pend = 0;
            if (lvl_tag != "") tg = lvl_tag;
        end
        @(negedge clk);
        cn_valid_i = 1'b0;
        chk(out_valid_o == ev, ee ? "R5" : (ev ? "R3" : "R4"), out_valid_o, ev);
        if (ev) begin
            chk(int'(out_run_o) == er, ee ? "R5" : "R3", out_run_o, er);
            chk(int'(out_level_o) == el, tg, out_level_o, el);
            chk(out_esc_o == ee, ee ? "R5" : "R3", out_esc_o, ee);
        end
    endtask

    initial begin
        void'($urandom(32'h1D2E3F));
        rst_n = 1'b0; cn_valid_i = 1'b0; cn_value_i = '0; tbl_sel_i = '0;
        repeat (3) @(negedge clk);
        chk(out_valid_o == 1'b0, "R1", out_valid_o, 0);
        chk(cn_ready_o == 1'b0, "R1", cn_ready_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid_o == 1'b0, "R1", out_valid_o, 0);
        chk(cn_ready_o == 1'b1, "R10", cn_ready_o, 1);

        // Directed: normal boundaries (R2, R3)
        push(0, 0);
        push(58, 18);
        // Escape openers at the threshold, even and odd (R4, R6)
        push(59, 3);  push(10, 3);
        push(60, 7);  push(4, 7);
        // Difference above the threshold is still a difference (R5)
        push(61, 2);  push(70, 2);
        // Largest unclamped run, then clamped runs (R8)
        push(186, 1); push(1, 1);
        push(188, 4); push(0, 4);
        push(4095, 9); push(3, 9);
        // Magnitude saturation, odd opener (R7)
        ref_force = 1; ref_alt = 2000;
        push(63, 5);  push(100, 5);
        // Reference captured at opener; later changes ignored, idle gap (R11, R9)
        ref_alt = 100;
        push(62, 6);
        ref_alt = 1500;
        idle(3);
        lvl_tag = "R11";
        push(5, 6);
        lvl_tag = "";
        ref_force = 0;
        idle(2);

        // Random mix
        for (int it = 0; it < 400; it++) begin
            int cn, tbl;
            tbl = int'($urandom % 19);
            if (!m_pend)
                cn = ($urandom % 2) ? int'($urandom % 59) : 59 + int'($urandom % (4096 - 59));
            else
                cn = ($urandom % 2) ? int'($urandom % 64) : int'($urandom % 4096);
            push(cn, tbl);
            idle(int'($urandom % 3));
        end
        if (m_pend) push(1, 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule